// File: doc/BRIEF.md
# Integer Execute Unit with Shifter

A purely combinational 32-bit execute stage for a small load/store processor core. Each cycle the unit is handed the value of the first source register, the value of the second source register, the 16-bit immediate field, the 5-bit shift-amount field, the 6-bit primary opcode and the 6-bit function code. It decodes the opcode and function fields itself and returns one 32-bit result plus a zero flag. It does not take a pre-decoded ALU operation.

Supported work covers add and subtract, add with a sign-extended immediate, bitwise AND, OR and NOR with their immediate variants, logical shifts by a constant amount, signed set-on-less-than in register and immediate forms, and loading an upper immediate. For loads and stores the result is the byte address formed from the base register and the displacement. Any encoding outside this set yields a zero result and raises an illegal-instruction flag.

Top module: `exec_unit`

## Requirements
- R1: With opcode 000000 and function 100000, result equals src_a + src_b modulo 2^32.
- R2: With opcode 000000 and function 100010, result equals src_a - src_b modulo 2^32.
- R3: With opcode 000000, function 100100 gives src_a AND src_b, 100101 gives src_a OR src_b, and 100111 gives NOT(src_a OR src_b).
- R4: Opcode 001100 gives src_a AND the zero-extended immediate, and opcode 001101 gives src_a OR the zero-extended immediate.
- R5: Opcode 001000 gives src_a plus the immediate sign-extended from bit 15.
- R6: With opcode 000000 and function 000000, result is src_b shifted left by shamt with zeros entering the low bits.
- R7: With opcode 000000 and function 000010, result is src_b shifted right by shamt with zeros entering the high bits.
- R8: Opcode 000000 with function 101010 returns 1 when src_a is less than src_b as signed two's complement, else 0; opcode 001010 does the same against the sign-extended immediate.
- R9: Opcode 001111 returns the immediate in bits 31:16 and zeros in bits 15:0.
- R10: Opcodes 100011 and 100000 (loads) and 101011 and 101000 (stores) return src_a plus the sign-extended immediate as a byte address.
- R11: The zero output is 1 exactly when the 32-bit result is zero.
- R12: Any other opcode, or opcode 000000 with any other function code, returns result 0 with illegal at 1; every supported encoding leaves illegal at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode field |
| fn_code | input | 6 | Function code, used when op_code is 000000 |
| src_a | input | 32 | First source register value (base for address) |
| src_b | input | 32 | Second source register value (shift operand) |
| imm16 | input | 16 | Immediate or displacement field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Computed value or byte address |
| zero | output | 1 | High when result is zero |
| illegal | output | 1 | High for an unsupported encoding |

## Verification
Every output is combinational, so a result is due in the same cycle its inputs are applied, with no register in the path. The bench changes the inputs just after a rising edge and compares result, zero and illegal against its own model at the following falling edge, half a period later, once the logic has settled. Nothing is carried from one cycle to the next, so each cycle is checked on its own.

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5
) (
  input  logic [5:0]       op_code,
  input  logic [5:0]       fn_code,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [SH_W-1:0]  shamt,
  output logic [XLEN-1:0]  result,
  output logic             zero,
  output logic             illegal
);
  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_SLTI = 6'b001010;
  localparam logic [5:0] OP_ANDI = 6'b001100;
  localparam logic [5:0] OP_ORI  = 6'b001101;
  localparam logic [5:0] OP_LUI  = 6'b001111;
  localparam logic [5:0] OP_LDW  = 6'b100011;
  localparam logic [5:0] OP_LDB  = 6'b100000;
  localparam logic [5:0] OP_STW  = 6'b101011;
  localparam logic [5:0] OP_STB  = 6'b101000;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam int EXT_W = XLEN - IMM_W;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLL, K_SRL, K_SLT, K_LUI, K_BAD
  } kind_t;

  kind_t           kind;
  logic            use_imm;
  logic            imm_zext;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic            sub_en;
  logic [XLEN-1:0] sum;
  logic            less;

  always_comb begin
    kind     = K_BAD;
    use_imm  = 1'b1;
    imm_zext = 1'b0;
    if (op_code == OP_REG) begin
      use_imm = 1'b0;
      case (fn_code)
        FN_ADD:  kind = K_ADD;
        FN_SUB:  kind = K_SUB;
        FN_AND:  kind = K_AND;
        FN_OR:   kind = K_OR;
        FN_NOR:  kind = K_NOR;
        FN_SLL:  kind = K_SLL;
        FN_SRL:  kind = K_SRL;
        FN_SLT:  kind = K_SLT;
        default: kind = K_BAD;
      endcase
    end else begin
      case (op_code)
        OP_ADDI, OP_LDW, OP_LDB, OP_STW, OP_STB: kind = K_ADD;
        OP_SLTI: kind = K_SLT;
        OP_ANDI: begin kind = K_AND; imm_zext = 1'b1; end
        OP_ORI:  begin kind = K_OR;  imm_zext = 1'b1; end
        OP_LUI:  kind = K_LUI;
        default: kind = K_BAD;
      endcase
    end
  end

  assign imm_ext = imm_zext ? {{EXT_W{1'b0}}, imm16}
                            : {{EXT_W{imm16[IMM_W-1]}}, imm16};
  assign opnd_b  = use_imm ? imm_ext : src_b;

  assign sub_en = (kind == K_SUB) || (kind == K_SLT);
  assign sum    = src_a + (sub_en ? ~opnd_b : opnd_b) + {{(XLEN-1){1'b0}}, sub_en};
  assign less   = (src_a[XLEN-1] != opnd_b[XLEN-1]) ? src_a[XLEN-1] : sum[XLEN-1];

  always_comb begin
    case (kind)
      K_ADD, K_SUB: result = sum;
      K_AND:        result = src_a & opnd_b;
      K_OR:         result = src_a | opnd_b;
      K_NOR:        result = ~(src_a | opnd_b);
      K_SLL:        result = src_b << shamt;
      K_SRL:        result = src_b >> shamt;
      K_SLT:        result = {{(XLEN-1){1'b0}}, less};
      K_LUI:        result = {imm16, {EXT_W{1'b0}}};
      default:      result = '0;
    endcase
  end

  assign illegal = (kind == K_BAD);
  assign zero    = (result == '0);
endmodule

module exec_unit_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5
) (
  input logic [5:0]       op_code,
  input logic [5:0]       fn_code,
  input logic [XLEN-1:0]  src_a,
  input logic [XLEN-1:0]  src_b,
  input logic [IMM_W-1:0] imm16,
  input logic [SH_W-1:0]  shamt,
  input logic [XLEN-1:0]  result,
  input logic             zero,
  input logic             illegal
);
  logic [XLEN-1:0] low_mask;
  logic [XLEN-1:0] high_mask;
  assign low_mask  = ~({XLEN{1'b1}} << shamt);
  assign high_mask = ~({XLEN{1'b1}} >> shamt);

  always_comb begin
    // R12
    illegal_zero_chk: assert (!illegal || (result == '0 && zero));
    // R9
    lui_low_chk: assert (op_code != 6'b001111 || result[XLEN-IMM_W-1:0] == '0);
    // R8
    slt_bool_chk: assert (!((op_code == 6'b001010) || (op_code == 6'b000000 && fn_code == 6'b101010))
                          || result[XLEN-1:1] == '0);
    // R6
    sll_fill_chk: assert (!(op_code == 6'b000000 && fn_code == 6'b000000) || (result & low_mask) == '0);
    // R7
    srl_fill_chk: assert (!(op_code == 6'b000000 && fn_code == 6'b000010) || (result & high_mask) == '0);
    // R11
    zero_flag_chk: assert (zero == (result == '0));
  end
endmodule

bind exec_unit exec_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
  .op_code(op_code), .fn_code(fn_code), .src_a(src_a), .src_b(src_b),
  .imm16(imm16), .shamt(shamt), .result(result), .zero(zero), .illegal(illegal)
);

// File: tb/exec_unit_bench.sv
module exec_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [5:0]  op_code, fn_code;
  logic [31:0] src_a, src_b;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        zero, illegal;

  int total = 0;
  int bad   = 0;

  exec_unit u_exec_unit (
    .op_code(op_code), .fn_code(fn_code), .src_a(src_a), .src_b(src_b),
    .imm16(imm16), .shamt(shamt), .result(result), .zero(zero), .illegal(illegal)
  );

  function automatic void model(input logic [5:0] op, input logic [5:0] fn,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh,
                                output logic [31:0] r, output logic ill, output string tag);
    longint sa, sb, si;
    logic [31:0] se;
    se  = {{16{im[15]}}, im};
    sa  = longint'($signed(a));
    sb  = longint'($signed(b));
    si  = longint'($signed(se));
    r   = 32'h0;
    ill = 1'b0;
    tag = "R12";
    if (op == 6'd0) begin
      if      (fn == 6'b100000) begin r = a + b;  tag = "R1"; end
      else if (fn == 6'b100010) begin r = a - b;  tag = "R2"; end
      else if (fn == 6'b100100) begin r = a & b;  tag = "R3"; end
      else if (fn == 6'b100101) begin r = a | b;  tag = "R3"; end
      else if (fn == 6'b100111) begin r = ~(a | b); tag = "R3"; end
      else if (fn == 6'b000000) begin r = b << sh; tag = "R6"; end
      else if (fn == 6'b000010) begin r = b >> sh; tag = "R7"; end
      else if (fn == 6'b101010) begin r = (sa < sb) ? 32'd1 : 32'd0; tag = "R8"; end
      else ill = 1'b1;
    end
    else if (op == 6'b001000) begin r = a + se; tag = "R5"; end
    else if (op == 6'b001100) begin r = a & {16'h0, im}; tag = "R4"; end
    else if (op == 6'b001101) begin r = a | {16'h0, im}; tag = "R4"; end
    else if (op == 6'b001010) begin r = (sa < si) ? 32'd1 : 32'd0; tag = "R8"; end
    else if (op == 6'b001111) begin r = {im, 16'h0}; tag = "R9"; end
    else if (op == 6'b100011 || op == 6'b100000 || op == 6'b101011 || op == 6'b101000) begin
      r = a + se; tag = "R10";
    end
    else ill = 1'b1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] er;
    logic        ei;
    string       tg;
    @(posedge clk);
    #1;
    op_code = op; fn_code = fn; src_a = a; src_b = b; imm16 = im; shamt = sh;
    @(negedge clk);
    model(op, fn, a, b, im, sh, er, ei, tg);
    check(tg, result, er);
    check(ei ? "R12 illegal" : "R12 legal", {31'h0, illegal}, {31'h0, ei});
    check("R11", {31'h0, zero}, {31'h0, (er == 32'h0)});
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] ops [0:9];
    logic [5:0] fns [0:7];
    ops = '{6'b000000, 6'b001000, 6'b001010, 6'b001100, 6'b001101,
            6'b001111, 6'b100011, 6'b100000, 6'b101011, 6'b101000};
    fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101,
            6'b100111, 6'b000000, 6'b000010, 6'b101010};
    rst_n = 1'b0;
    op_code = '0; fn_code = '0; src_a = '0; src_b = '0; imm16 = '0; shamt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero inputs, a shift of zero (R6), zero flag up (R11)
    check("R6 reset", result, 32'h0);
    check("R11 reset", {31'h0, zero}, 32'h1);
    check("R12 reset", {31'h0, illegal}, 32'h0);
    rst_n = 1'b1;

    apply(6'd0, 6'b100000, 32'h7fffffff, 32'h1, 16'h0, 5'd0);       // R1 wrap
    apply(6'd0, 6'b100000, 32'hffffffff, 32'h1, 16'h0, 5'd0);       // R1 to zero
    apply(6'd0, 6'b100010, 32'h1234, 32'h1234, 16'h0, 5'd0);        // R2 zero
    apply(6'd0, 6'b100010, 32'h0, 32'h1, 16'h0, 5'd0);              // R2 borrow
    apply(6'd0, 6'b100111, 32'h0f0f0000, 32'h0, 16'h0, 5'd0);       // R3 not
    apply(6'd0, 6'b100100, 32'hff00ff00, 32'h0ff00ff0, 16'h0, 5'd0);// R3 and
    apply(6'b001100, 6'd0, 32'hffffffff, 32'h0, 16'hffff, 5'd0);    // R4 zext
    apply(6'b001101, 6'd0, 32'h0, 32'h0, 16'h8001, 5'd0);           // R4 zext
    apply(6'b001000, 6'd0, 32'h10, 32'h0, 16'hfff0, 5'd0);          // R5 neg
    apply(6'd0, 6'b000000, 32'h0, 32'h00000003, 16'h0, 5'd31);      // R6 max
    apply(6'd0, 6'b000000, 32'h0, 32'hdeadbeef, 16'h0, 5'd0);       // R6 none
    apply(6'd0, 6'b000010, 32'h0, 32'h80000000, 16'h0, 5'd31);      // R7 max
    apply(6'd0, 6'b101010, 32'hffffffff, 32'h1, 16'h0, 5'd0);       // R8 -1<1
    apply(6'd0, 6'b101010, 32'h1, 32'hffffffff, 16'h0, 5'd0);       // R8 1<-1
    apply(6'd0, 6'b101010, 32'h80000000, 32'h7fffffff, 16'h0, 5'd0);// R8 extremes
    apply(6'd0, 6'b101010, 32'h5, 32'h5, 16'h0, 5'd0);              // R8 equal
    apply(6'b001010, 6'd0, 32'hffff0000, 32'h0, 16'h8000, 5'd0);    // R8 imm
    apply(6'b001111, 6'd0, 32'hffffffff, 32'h0, 16'habcd, 5'd7);    // R9
    apply(6'b100011, 6'd0, 32'h1000, 32'h0, 16'hfffc, 5'd0);        // R10 load
    apply(6'b101000, 6'd0, 32'h1000, 32'h0, 16'h0030, 5'd0);        // R10 store
    apply(6'b111111, 6'd0, 32'h5, 32'h5, 16'h5, 5'd5);              // R12 op
    apply(6'd0, 6'b000001, 32'h5, 32'h5, 16'h5, 5'd5);              // R12 fn

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op, fn;
      int pick;
      pick = $urandom_range(0, 9);
      op = ops[pick];
      fn = fns[$urandom_range(0, 7)];
      if ($urandom_range(0, 9) == 0) begin op = 6'($urandom); fn = 6'($urandom); end
      apply(op, fn, $urandom, ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom,
            16'($urandom), 5'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule